// File: doc/BRIEF.md
# Instruction Control Decoder with Branch Resolution

This block takes one 32-bit instruction word together with the current program counter, the saved return address (the content of the link register) and the stored comparison flags. From these it produces the complete set of control strobes for a small 32-bit RISC core, and the core acts on the result one clock later. The 5-bit operation code in the top bits of the word picks exactly one operation out of 21. The bit just below the operation code marks the second operand as an immediate.

The same pass also resolves control flow. It computes the branch destination, which is either the word-scaled signed offset added to the PC or, for a return, the saved return address. It decides from the branch strobes and the flags whether the branch is taken, and it picks the next PC. A call writes its return address, PC+4, into register 15, so the destination index is forced to 15 for a call. Operation codes 21 to 31 are not defined. For these the block raises an illegal flag, asserts no strobe and lets execution fall through to the next word.

Every output is registered behind a synchronous active-high reset.

Top module: `ctl_decoder_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is driven to zero after that edge.
- R2: The operation code is `instr_i[31:27]`, and the outputs show the decode of the inputs one clock edge later. Codes 0 to 12 (add, sub, mul, div, mod, cmp, and, or, not, mov, lsl, lsr, asr) each set only `ctl_o` bit N, where N equals the code.
- R3: Code 14 (load) sets `ctl_o[13]`. Code 15 (store) sets `ctl_o[14]`. Code 16 (branch if equal) sets `ctl_o[15]`. Code 17 (branch if greater) sets `ctl_o[16]`. Code 13 (no-op) sets no strobe in `ctl_o[19:0]`.
- R4: `ctl_o[17]` marks an unconditional transfer and is set for code 18 (jump), code 19 (call, which also sets `ctl_o[18]`) and code 20 (return, which also sets `ctl_o[19]`).
- R5: The register write enable `ctl_o[20]` is set for codes 0 to 12 except 5 (cmp), and for codes 14 and 19. It is clear for every other code.
- R6: The immediate flag `ctl_o[21]` copies `instr_i[26]` for codes 0 to 12, 14 and 15, and is 0 for all other codes.
- R7: Codes 21 to 31 set `illegal_o` and clear all of `ctl_o` and `branch_taken_o`. All legal codes clear `illegal_o`.
- R8: `branch_taken_o` = `ctl_o[17]` OR (`ctl_o[15]` AND eq flag) OR (`ctl_o[16]` AND gt flag).
- R9: `branch_pc_o` is `link_val_i` for a return. For every other code it is `pc_i` plus four times the sign-extended `instr_i[26:0]`, modulo 2^32.
- R10: `next_pc_o` equals `branch_pc_o` when the branch is taken, and `pc_i`+4 otherwise. `seq_pc_o` is always `pc_i`+4, which is the value a call stores into the link register.
- R11: `wb_dst_o` is 15 for a call and `instr_i[25:22]` for every other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word to decode |
| pc_i | input | 32 | Address of that instruction |
| link_val_i | input | 32 | Value read from register 15 |
| flag_gt_i | input | 1 | Stored greater-than flag |
| flag_eq_i | input | 1 | Stored equal flag |
| ctl_o | output | 22 | Control strobes, bit positions as in R2 to R6 |
| illegal_o | output | 1 | Undefined operation code |
| wb_dst_o | output | 4 | Destination register index |
| branch_pc_o | output | 32 | Branch destination |
| branch_taken_o | output | 1 | Control transfer taken |
| next_pc_o | output | 32 | Selected next PC |
| seq_pc_o | output | 32 | PC + 4 |

## Verification
The assertions take the instruction word, PC, return value and flags to be known (not X) at every clock edge once reset has dropped. They check registered outputs against the inputs sampled one edge earlier. The stimulus meets these conditions because it drives every input at the falling edge and holds reset high from time zero. It walks all 32 operation codes with both immediate settings and all four flag combinations, then adds offsets at both signed extremes, a PC near the top of the address space, random words, and a reset applied in the middle of the run.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;
  localparam int OPW     = 5;
  localparam int NUM_OPS = 21;
  localparam int CTL_W   = 22;
  localparam int ILEN    = 32;
  localparam int OFFW    = 27;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_SUB = 5'd1,  OP_MUL = 5'd2,  OP_DIV = 5'd3,
    OP_MOD = 5'd4,  OP_CMP = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_NOT = 5'd8,  OP_MOV = 5'd9,  OP_LSL = 5'd10, OP_LSR = 5'd11,
    OP_ASR = 5'd12, OP_NOP = 5'd13, OP_LD  = 5'd14, OP_ST  = 5'd15,
    OP_BEQ = 5'd16, OP_BGT = 5'd17, OP_B   = 5'd18, OP_CALL = 5'd19,
    OP_RET = 5'd20
  } op_e;

  // Strobe positions inside the control vector
  localparam int C_CMP  = 5;
  localparam int C_ALU_TOP = 12;
  localparam int C_LD   = 13;
  localparam int C_ST   = 14;
  localparam int C_BEQ  = 15;
  localparam int C_BGT  = 16;
  localparam int C_UBR  = 17;
  localparam int C_CALL = 18;
  localparam int C_RET  = 19;
  localparam int C_WB   = 20;
  localparam int C_IMM  = 21;
endpackage

// File: rtl/ctl_opdec.sv
module ctl_opdec
  import ctl_dec_pkg::*;
(
  input  logic [OPW-1:0]   opcode_i,
  input  logic             imm_bit_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             illegal_o
);
  logic [NUM_OPS-1:0] op_hot;

  genvar i;
  generate
    for (i = 0; i < NUM_OPS; i++) begin : g_hot
      assign op_hot[i] = (opcode_i == OPW'(i));
    end
  endgenerate

  logic alu_any;
  assign alu_any = |op_hot[C_ALU_TOP:0];

  always_comb begin
    ctl_o = '0;
    ctl_o[C_ALU_TOP:0] = op_hot[C_ALU_TOP:0];
    ctl_o[C_LD]   = op_hot[OP_LD];
    ctl_o[C_ST]   = op_hot[OP_ST];
    ctl_o[C_BEQ]  = op_hot[OP_BEQ];
    ctl_o[C_BGT]  = op_hot[OP_BGT];
    ctl_o[C_UBR]  = op_hot[OP_B] | op_hot[OP_CALL] | op_hot[OP_RET];
    ctl_o[C_CALL] = op_hot[OP_CALL];
    ctl_o[C_RET]  = op_hot[OP_RET];
    ctl_o[C_WB]   = (alu_any & ~op_hot[OP_CMP]) | op_hot[OP_LD] | op_hot[OP_CALL];
    ctl_o[C_IMM]  = imm_bit_i & (alu_any | op_hot[OP_LD] | op_hot[OP_ST]);
  end

  assign illegal_o = ~|op_hot;
endmodule

// File: rtl/ctl_branch.sv
module ctl_branch #(
  parameter int XLEN = 32,
  parameter int OFFW = 27
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [XLEN-1:0] link_val_i,
  input  logic            ubr_i,
  input  logic            beq_i,
  input  logic            bgt_i,
  input  logic            ret_i,
  input  logic            gt_i,
  input  logic            eq_i,
  output logic [XLEN-1:0] branch_pc_o,
  output logic            taken_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] seq_pc_o
);
  localparam int EXTW = XLEN - OFFW;

  logic [XLEN-1:0] off_ext;
  logic [XLEN-1:0] rel_target;

  assign off_ext     = {{EXTW{off_i[OFFW-1]}}, off_i};
  assign rel_target  = pc_i + (off_ext << 2);
  assign seq_pc_o    = pc_i + XLEN'(4);
  assign branch_pc_o = ret_i ? link_val_i : rel_target;
  assign taken_o     = ubr_i | (beq_i & eq_i) | (bgt_i & gt_i);
  assign next_pc_o   = taken_o ? branch_pc_o : seq_pc_o;
endmodule

// File: rtl/ctl_decoder_top.sv
module ctl_decoder_top
  import ctl_dec_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int REGW     = 4,
  parameter int LINK_REG = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ILEN-1:0]  instr_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  link_val_i,
  input  logic             flag_gt_i,
  input  logic             flag_eq_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             illegal_o,
  output logic [REGW-1:0]  wb_dst_o,
  output logic [XLEN-1:0]  branch_pc_o,
  output logic             branch_taken_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic [XLEN-1:0]  seq_pc_o
);
  localparam int OP_LSB = ILEN - OPW;
  localparam int RD_LSB = OP_LSB - 1 - REGW;

  logic [OPW-1:0]   opcode;
  logic [CTL_W-1:0] ctl_d;
  logic             illegal_d;
  logic [XLEN-1:0]  bpc_d, npc_d, seq_d;
  logic             taken_d;
  logic [REGW-1:0]  dst_d;

  assign opcode = instr_i[ILEN-1:OP_LSB];

  ctl_opdec u_opdec (
    .opcode_i  (opcode),
    .imm_bit_i (instr_i[OP_LSB-1]),
    .ctl_o     (ctl_d),
    .illegal_o (illegal_d)
  );

  ctl_branch #(.XLEN(XLEN), .OFFW(OFFW)) u_branch (
    .pc_i        (pc_i),
    .off_i       (instr_i[OFFW-1:0]),
    .link_val_i  (link_val_i),
    .ubr_i       (ctl_d[C_UBR]),
    .beq_i       (ctl_d[C_BEQ]),
    .bgt_i       (ctl_d[C_BGT]),
    .ret_i       (ctl_d[C_RET]),
    .gt_i        (flag_gt_i),
    .eq_i        (flag_eq_i),
    .branch_pc_o (bpc_d),
    .taken_o     (taken_d),
    .next_pc_o   (npc_d),
    .seq_pc_o    (seq_d)
  );

  assign dst_d = ctl_d[C_CALL] ? REGW'(LINK_REG) : instr_i[RD_LSB +: REGW];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_o          <= '0;
      illegal_o      <= 1'b0;
      wb_dst_o       <= '0;
      branch_pc_o    <= '0;
      branch_taken_o <= 1'b0;
      next_pc_o      <= '0;
      seq_pc_o       <= '0;
    end else begin
      ctl_o          <= ctl_d;
      illegal_o      <= illegal_d;
      wb_dst_o       <= dst_d;
      branch_pc_o    <= bpc_d;
      branch_taken_o <= taken_d;
      next_pc_o      <= npc_d;
      seq_pc_o       <= seq_d;
    end
  end

  // R2: at most one operation strobe (transfer marker excluded)
  a_r2_op_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_o[C_RET:C_CALL], ctl_o[C_BGT:0]}));

  // R7: undefined codes produce no strobes and no transfer
  a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    (opcode >= 5'd21) |=> (illegal_o && ctl_o == '0 && !branch_taken_o));

  // R5: compare, store and return never write a register
  a_r5_no_wb: assert property (@(posedge clk) disable iff (rst)
    (ctl_o[C_CMP] || ctl_o[C_ST] || ctl_o[C_RET]) |-> !ctl_o[C_WB]);

  // R9: return jumps to the link register value
  a_r9_ret_target: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_RET) |=> (branch_taken_o && branch_pc_o == $past(link_val_i)));

  // R10: fall-through when not taken
  a_r10_fallthrough: assert property (@(posedge clk) disable iff (rst)
    !branch_taken_o |-> (next_pc_o == seq_pc_o));

  // R11: a call writes the link register
  a_r11_call_dst: assert property (@(posedge clk) disable iff (rst)
    ctl_o[C_CALL] |-> (wb_dst_o == REGW'(LINK_REG)));
endmodule

// File: tb/ctl_decoder_top_tb_top.sv
module ctl_decoder_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] link_val_i = '0;
  logic        flag_gt_i = 1'b0;
  logic        flag_eq_i = 1'b0;
  logic [21:0] ctl_o;
  logic        illegal_o;
  logic [3:0]  wb_dst_o;
  logic [31:0] branch_pc_o;
  logic        branch_taken_o;
  logic [31:0] next_pc_o;
  logic [31:0] seq_pc_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctl_decoder_top dut_i (
    .clk(clk), .rst(rst), .instr_i(instr_i), .pc_i(pc_i),
    .link_val_i(link_val_i), .flag_gt_i(flag_gt_i), .flag_eq_i(flag_eq_i),
    .ctl_o(ctl_o), .illegal_o(illegal_o), .wb_dst_o(wb_dst_o),
    .branch_pc_o(branch_pc_o), .branch_taken_o(branch_taken_o),
    .next_pc_o(next_pc_o), .seq_pc_o(seq_pc_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference; expected values queued per cycle
  logic [31:0] q_ctl[$], q_ill[$], q_dst[$], q_bpc[$], q_tk[$], q_npc[$], q_seq[$];

  task automatic model(input logic [31:0] ins, input logic [31:0] pc,
                       input logic [31:0] lnk, input logic gt, input logic eq);
    int op;
    logic [21:0] c;
    logic signed [31:0] soff;
    logic [31:0] tgt, bpc;
    logic taken;
    op = int'(ins[31:27]);
    c = '0;
    if (op <= 12) c[op] = 1'b1;               // R2
    if (op == 14) c[13] = 1'b1;               // R3
    if (op == 15) c[14] = 1'b1;
    if (op == 16) c[15] = 1'b1;
    if (op == 17) c[16] = 1'b1;
    if (op == 18 || op == 19 || op == 20) c[17] = 1'b1; // R4
    if (op == 19) c[18] = 1'b1;
    if (op == 20) c[19] = 1'b1;
    c[20] = ((op <= 12) && (op != 5)) || op == 14 || op == 19; // R5
    c[21] = ins[26] && ((op <= 12) || op == 14 || op == 15);   // R6
    taken = c[17] || (c[15] && eq) || (c[16] && gt);           // R8
    soff = {{5{ins[26]}}, ins[26:0]};
    tgt = pc + 32'(soff * 4);
    bpc = (op == 20) ? lnk : tgt;                              // R9
    q_ctl.push_back(32'(c));
    q_ill.push_back(32'(op >= 21));
    q_dst.push_back((op == 19) ? 32'd15 : 32'(ins[25:22]));
    q_bpc.push_back(bpc);
    q_tk.push_back(32'(taken));
    q_npc.push_back(taken ? bpc : pc + 32'd4);
    q_seq.push_back(pc + 32'd4);
  endtask

  task automatic step(input logic [31:0] ins, input logic [31:0] pc,
                      input logic [31:0] lnk, input logic gt, input logic eq);
    @(negedge clk);
    instr_i = ins; pc_i = pc; link_val_i = lnk; flag_gt_i = gt; flag_eq_i = eq;
    model(ins, pc, lnk, gt, eq);
    @(posedge clk);
    #1;
    chk("R2-R7 ctl", "ctl_o", 32'(ctl_o), q_ctl.pop_front());
    chk("R7", "illegal_o", 32'(illegal_o), q_ill.pop_front());
    chk("R11", "wb_dst_o", 32'(wb_dst_o), q_dst.pop_front());
    chk("R9", "branch_pc_o", branch_pc_o, q_bpc.pop_front());
    chk("R8", "branch_taken_o", 32'(branch_taken_o), q_tk.pop_front());
    chk("R10", "next_pc_o", next_pc_o, q_npc.pop_front());
    chk("R10", "seq_pc_o", seq_pc_o, q_seq.pop_front());
  endtask

  task automatic reset_check();
    @(posedge clk);
    #1;
    chk("R1", "ctl_o", 32'(ctl_o), 32'd0);
    chk("R1", "illegal_o", 32'(illegal_o), 32'd0);
    chk("R1", "wb_dst_o", 32'(wb_dst_o), 32'd0);
    chk("R1", "branch_pc_o", branch_pc_o, 32'd0);
    chk("R1", "branch_taken_o", 32'(branch_taken_o), 32'd0);
    chk("R1", "next_pc_o", next_pc_o, 32'd0);
    chk("R1", "seq_pc_o", seq_pc_o, 32'd0);
  endtask

  initial begin
    reset_check();
    reset_check();
    @(negedge clk);
    rst = 1'b0;
    // Every opcode, both immediate settings, all flag combinations
    for (int op = 0; op < 32; op++) begin
      for (int k = 0; k < 8; k++) begin
        step({5'(op), k[0], 4'(op), 22'h15A5C3}, 32'h0000_1000 + 32'(op * 64),
             32'hCAFE_0000 + 32'(op), k[1], k[2]);
      end
    end
    // Offset extremes and address wrap (R9)
    step({5'd18, 27'h3FF_FFFF}, 32'h0000_0100, 32'h0, 1'b0, 1'b0);
    step({5'd18, 27'h400_0000}, 32'h8000_0000, 32'h0, 1'b0, 1'b0);
    step({5'd16, 27'h7FF_FFFF}, 32'hFFFF_FFFC, 32'h0, 1'b0, 1'b1);
    step({5'd19, 27'h000_0001}, 32'hFFFF_FFFC, 32'h0, 1'b0, 1'b0);
    step({5'd20, 27'h123_4567}, 32'h0000_2000, 32'hDEAD_BEE0, 1'b1, 1'b1);
    // Random words
    for (int n = 0; n < 400; n++) begin
      step($urandom, $urandom, $urandom, 1'($urandom), 1'($urandom));
    end
    // Reset in mid-run with a taken call on the inputs (R1)
    @(negedge clk);
    rst = 1'b1;
    instr_i = {5'd19, 27'h55};
    reset_check();
    @(negedge clk);
    rst = 1'b0;
    step({5'd19, 27'h55}, 32'h40, 32'h0, 1'b0, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule